// File: doc/BRIEF.md
# Two-Way Data Address Translation Buffer

This block maps effective addresses of data loads and stores onto real addresses using a small set-associative table of 4 KiB page translations. A requester presents an effective address together with a translate-enable bit. One clock later the block returns a hit flag, the real address and a cache-inhibit flag. With translation disabled the address is passed straight through. In that real mode, one fixed 256 MiB address window is always marked cache-inhibited.

The table is maintained only by software commands on a separate command port. Each command carries an operand word and a data word. The low control field of the operand selects one of three actions: clear the whole table, clear the entry for one page, or write a new entry whose real page number and cache-inhibit attribute come from the data word. A translated lookup that finds no entry reports a miss and nothing else. Page-table walking, access protection and exception generation belong to other blocks.

Top module: `xlat_dtlb`

## Requirements
- R1: After reset every entry is invalid, so a translated lookup misses, and `res_valid` is low until a lookup is made.
- R2: Results are registered. `res_valid` is high in exactly the cycle after a cycle with `lk_valid` high. When there was no lookup, `res_hit`, `res_ra` and `res_ci` are zero.
- R3: With `lk_xlate` low, the result is a hit and `res_ra` equals `lk_ea`.
- R4: With `lk_xlate` low, `res_ci` is 1 exactly when `lk_ea[31:28]` equals 4'hC.
- R5: A translated hit returns `res_ra = {8'b0, stored page number, lk_ea[11:0]}` and `res_ci` equal to the stored attribute. The 0xC window has no effect in this mode.
- R6: A translated miss returns `res_hit = 0`, `res_ra = 0` and `res_ci = 0`.
- R7: The set index is address bits [17:12] (64 sets) and the tag is bits [63:18]. A command uses `cmd_op[63:12]` as its page number and `cmd_op[11:9]` as its action: 3'b001 writes an entry, any value with bit 11 or bit 10 set clears all entries, and 3'b000 clears one page.
- R8: An entry write records the page from `cmd_op[63:12]`, the real page number from `cmd_pte[55:12]`, and the cache-inhibit attribute from `cmd_pte[5]`.
- R9: An entry write picks its way in this order: a way already holding the same page; otherwise the first invalid way, way 0 before way 1; otherwise the way named by that set's round-robin bit. The round-robin bit starts at 0 and inverts on every write to its set.
- R10: A single-page clear removes only that page. The other way of the set stays, and so does the same tag held in another set.
- R11: A clear-all command makes every later translated lookup miss until new entries are written.
- R12: A lookup in the same cycle as a command sees the table as it was before that command. A lookup in the following cycle sees the command's effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request strobe |
| lk_ea | input | 64 | Effective address to translate |
| lk_xlate | input | 1 | 1 = translated mode, 0 = real mode |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 64 | Page number [63:12] and action field [11:9] |
| cmd_pte | input | 64 | Entry data word for entry writes |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | Translation found (always 1 in real mode) |
| res_ra | output | 64 | Real address |
| res_ci | output | 1 | Cache-inhibited access |

## Verification
Every lookup result appears exactly one clock after the request cycle, from the single result register. The bench therefore drives a request on a falling edge and reads the outputs on the next falling edge, after the one rising edge in between. A command is applied on the rising edge that ends its cycle. For that reason every check of a command's effect uses a lookup issued no earlier than the following cycle. The one exception is the deliberate same-cycle case, where the bench expects the old table contents. Replacement outcomes, page numbers and addresses are derived arithmetically from the set index and tag formulas the bench uses to build its pages.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;

    localparam int unsigned NUM_WAYS = 2;
    localparam int unsigned CTL_LSB  = 9;
    localparam int unsigned CTL_W    = 3;

    typedef enum logic [1:0] {
        TC_NONE,
        TC_DROP_PAGE,
        TC_DROP_ALL,
        TC_LOAD
    } tcmd_e;

endpackage

// File: rtl/dtlb_cmd_decode.sv
module dtlb_cmd_decode
    import dtlb_pkg::*;
(
    input  logic             cmd_valid,
    input  logic [CTL_W-1:0] ctl,
    output tcmd_e            kind
);

    always_comb begin
        if (!cmd_valid) begin
            kind = TC_NONE;
        end else if (ctl == 3'b001) begin
            kind = TC_LOAD;
        end else if (ctl[2:1] != 2'b00) begin
            kind = TC_DROP_ALL;
        end else begin
            kind = TC_DROP_PAGE;
        end
    end

endmodule

// File: rtl/dtlb_tag_cmp.sv
module dtlb_tag_cmp #(
    parameter int unsigned TAG_W = 46
) (
    input  logic             ent_vld,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [TAG_W-1:0] key,
    output logic             hit
);

    assign hit = ent_vld && (ent_tag == key);

endmodule

// File: rtl/dtlb_victim.sv
module dtlb_victim
    import dtlb_pkg::*;
(
    input  logic [NUM_WAYS-1:0] same_pg,
    input  logic [NUM_WAYS-1:0] vld,
    input  logic                rr,
    output logic                way
);

    always_comb begin
        if (same_pg[0]) begin
            way = 1'b0;
        end else if (same_pg[1]) begin
            way = 1'b1;
        end else if (!vld[0]) begin
            way = 1'b0;
        end else if (!vld[1]) begin
            way = 1'b1;
        end else begin
            way = rr;
        end
    end

endmodule

// File: rtl/xlat_dtlb.sv
module xlat_dtlb
    import dtlb_pkg::*;
#(
    parameter int unsigned EA_W       = 64,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned SET_BITS   = 6,
    parameter int unsigned RPN_W      = 44,
    parameter int unsigned CI_BIT     = 5,
    parameter int unsigned WIN_LSB    = 28,
    parameter logic [3:0]  REAL_CI_WIN = 4'hC
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_valid,
    input  logic [EA_W-1:0] lk_ea,
    input  logic            lk_xlate,
    input  logic            cmd_valid,
    input  logic [EA_W-1:0] cmd_op,
    input  logic [EA_W-1:0] cmd_pte,
    output logic            res_valid,
    output logic            res_hit,
    output logic [EA_W-1:0] res_ra,
    output logic            res_ci
);

    localparam int unsigned SETS  = 1 << SET_BITS;
    localparam int unsigned TAG_W = EA_W - PAGE_SHIFT - SET_BITS;
    localparam int unsigned PAD_W = EA_W - PAGE_SHIFT - RPN_W;
    localparam int unsigned IDX_LSB = PAGE_SHIFT;
    localparam int unsigned TAG_LSB = PAGE_SHIFT + SET_BITS;

    typedef struct packed {
        logic [SETS-1:0][NUM_WAYS-1:0]             vld;
        logic [SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][NUM_WAYS-1:0][RPN_W-1:0]  rpn;
        logic [SETS-1:0][NUM_WAYS-1:0]             ci;
        logic [SETS-1:0]                           rr;
        logic                                      res_valid;
        logic                                      res_hit;
        logic                                      res_ci;
        logic [EA_W-1:0]                           res_ra;
    } tlb_st_t;

    tlb_st_t st_d, st_q;

    logic [SET_BITS-1:0]              lk_set, cm_set;
    logic [TAG_W-1:0]                 lk_tag, cm_tag;
    logic [NUM_WAYS-1:0]              lk_vld_row, cm_vld_row;
    logic [NUM_WAYS-1:0][TAG_W-1:0]   lk_tag_row, cm_tag_row;
    logic [NUM_WAYS-1:0]              lk_match, cm_match;
    logic                             lk_way, fill_way;
    tcmd_e                            cmd_kind;

    assign lk_set = lk_ea[IDX_LSB +: SET_BITS];
    assign lk_tag = lk_ea[TAG_LSB +: TAG_W];
    assign cm_set = cmd_op[IDX_LSB +: SET_BITS];
    assign cm_tag = cmd_op[TAG_LSB +: TAG_W];

    assign lk_vld_row = st_q.vld[lk_set];
    assign lk_tag_row = st_q.tag[lk_set];
    assign cm_vld_row = st_q.vld[cm_set];
    assign cm_tag_row = st_q.tag[cm_set];

    generate
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
            dtlb_tag_cmp #(.TAG_W(TAG_W)) u_lk_cmp (
                .ent_vld (lk_vld_row[w]),
                .ent_tag (lk_tag_row[w]),
                .key     (lk_tag),
                .hit     (lk_match[w])
            );
            dtlb_tag_cmp #(.TAG_W(TAG_W)) u_cm_cmp (
                .ent_vld (cm_vld_row[w]),
                .ent_tag (cm_tag_row[w]),
                .key     (cm_tag),
                .hit     (cm_match[w])
            );
        end
    endgenerate

    assign lk_way = lk_match[1];

    dtlb_cmd_decode u_decode (
        .cmd_valid (cmd_valid),
        .ctl       (cmd_op[CTL_LSB +: CTL_W]),
        .kind      (cmd_kind)
    );

    dtlb_victim u_victim (
        .same_pg (cm_match),
        .vld     (cm_vld_row),
        .rr      (st_q.rr[cm_set]),
        .way     (fill_way)
    );

    logic unused_cmd_bits;
    assign unused_cmd_bits = ^{cmd_op[CTL_LSB-1:0], cmd_pte};

    always_comb begin
        st_d = st_q;

        st_d.res_valid = lk_valid;
        st_d.res_hit   = 1'b0;
        st_d.res_ci    = 1'b0;
        st_d.res_ra    = '0;
        if (lk_valid) begin
            if (!lk_xlate) begin
                st_d.res_hit = 1'b1;
                st_d.res_ra  = lk_ea;
                st_d.res_ci  = (lk_ea[WIN_LSB +: 4] == REAL_CI_WIN);
            end else if (|lk_match) begin
                st_d.res_hit = 1'b1;
                st_d.res_ra  = {{PAD_W{1'b0}}, st_q.rpn[lk_set][lk_way],
                                lk_ea[PAGE_SHIFT-1:0]};
                st_d.res_ci  = st_q.ci[lk_set][lk_way];
            end
        end

        case (cmd_kind)
            TC_DROP_ALL: begin
                st_d.vld = '0;
            end
            TC_DROP_PAGE: begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    if (cm_match[w]) begin
                        st_d.vld[cm_set][w] = 1'b0;
                    end
                end
            end
            TC_LOAD: begin
                st_d.vld[cm_set][fill_way] = 1'b1;
                st_d.tag[cm_set][fill_way] = cm_tag;
                st_d.rpn[cm_set][fill_way] = cmd_pte[PAGE_SHIFT +: RPN_W];
                st_d.ci[cm_set][fill_way]  = cmd_pte[CI_BIT];
                st_d.rr[cm_set]            = ~st_q.rr[cm_set];
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.res_valid;
    assign res_hit   = st_q.res_hit;
    assign res_ra    = st_q.res_ra;
    assign res_ci    = st_q.res_ci;

endmodule

// File: rtl/dtlb_checker.sv
module dtlb_checker #(
    parameter int unsigned EA_W       = 64,
    parameter int unsigned PAGE_SHIFT = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic [EA_W-1:0] lk_ea,
    input logic            lk_xlate,
    input logic            cmd_valid,
    input logic [EA_W-1:0] cmd_op,
    input logic            res_valid,
    input logic            res_hit,
    input logic [EA_W-1:0] res_ra,
    input logic            res_ci
);

    logic unused_chk;
    assign unused_chk = ^cmd_op[8:0];

    AST_RES_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid); // R2

    AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!res_valid && !res_hit && res_ra == '0 && !res_ci)); // R2

    AST_REAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_xlate) |=> (res_hit && res_ra == $past(lk_ea))); // R3

    AST_REAL_CI: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_xlate) |=> (res_ci == ($past(lk_ea[31:28]) == 4'hC))); // R4

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_ra == '0 && !res_ci)); // R6

    AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op[11:10] != 2'b00) ##1 (lk_valid && lk_xlate)
        |=> !res_hit); // R11

    AST_FILL_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op[11:9] == 3'b001) ##1
        (lk_valid && lk_xlate &&
         lk_ea[EA_W-1:PAGE_SHIFT] == $past(cmd_op[EA_W-1:PAGE_SHIFT]))
        |=> (res_hit && res_ra[PAGE_SHIFT-1:0] == $past(lk_ea[PAGE_SHIFT-1:0]))); // R8

endmodule

bind xlat_dtlb dtlb_checker #(
    .EA_W       (EA_W),
    .PAGE_SHIFT (PAGE_SHIFT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_ea     (lk_ea),
    .lk_xlate  (lk_xlate),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_ra    (res_ra),
    .res_ci    (res_ci)
);

// File: tb/xlat_dtlb_bench.sv
`timescale 1ns/1ps
module xlat_dtlb_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_ea = '0;
    logic        lk_xlate = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [63:0] cmd_op = '0;
    logic [63:0] cmd_pte = '0;
    logic        res_valid, res_hit, res_ci;
    logic [63:0] res_ra;

    int n_chk = 0;
    int n_fail = 0;
    logic finished = 1'b0;

    logic        g_vld, g_hit, g_ci;
    logic [63:0] g_ra;

    always #2 clk = ~clk;

    xlat_dtlb u_xlat_dtlb (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_ea(lk_ea), .lk_xlate(lk_xlate),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_pte(cmd_pte),
        .res_valid(res_valid), .res_hit(res_hit), .res_ra(res_ra), .res_ci(res_ci)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [45:0] tag_a(input int s);
        return 46'(s * 7 + 3);
    endfunction
    function automatic logic [45:0] tag_b(input int s);
        return tag_a(s) + 46'h1_0000_0000;
    endfunction
    function automatic logic [63:0] ea_of(input logic [45:0] t, input int s, input int off);
        return {t, 6'(s), 12'(off)};
    endfunction
    function automatic logic [43:0] rpn_of(input logic [45:0] t, input int s);
        return 44'({t, 6'(s)}) ^ 44'h95A3C0F1E77;
    endfunction
    function automatic logic [63:0] pte_of(input logic [43:0] rpn, input logic ci);
        return {8'h00, rpn, 6'h00, ci, 5'h00};
    endfunction
    function automatic logic [63:0] xl_ra(input logic [43:0] rpn, input int off);
        return {8'h00, rpn, 12'(off)};
    endfunction

    task automatic look(input logic [63:0] ea, input logic xl);
        @(negedge clk);
        lk_valid = 1'b1; lk_ea = ea; lk_xlate = xl;
        @(negedge clk);
        lk_valid = 1'b0;
        g_vld = res_valid; g_hit = res_hit; g_ra = res_ra; g_ci = res_ci;
    endtask

    task automatic cmd(input logic [63:0] op, input logic [63:0] pte);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_pte = pte;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic look_cmd(input logic [63:0] ea, input logic [63:0] op, input logic [63:0] pte);
        @(negedge clk);
        lk_valid = 1'b1; lk_ea = ea; lk_xlate = 1'b1;
        cmd_valid = 1'b1; cmd_op = op; cmd_pte = pte;
        @(negedge clk);
        lk_valid = 1'b0; cmd_valid = 1'b0;
        g_vld = res_valid; g_hit = res_hit; g_ra = res_ra; g_ci = res_ci;
    endtask

    task automatic fill(input logic [45:0] t, input int s, input logic [43:0] rpn, input logic ci);
        cmd({t, 6'(s), 12'h200}, pte_of(rpn, ci));
    endtask

    task automatic expect_hit(input string req, input logic [45:0] t, input int s,
                              input logic [43:0] rpn, input logic ci);
        look(ea_of(t, s, s * 13 + 5), 1'b1);
        chk({req, " hit"}, 64'(g_hit), 64'd1);
        chk({req, " ra"}, g_ra, xl_ra(rpn, s * 13 + 5));
        chk({req, " ci"}, 64'(g_ci), 64'(ci));
    endtask

    task automatic expect_miss(input string req, input logic [45:0] t, input int s);
        look(ea_of(t, s, 12'h0F0), 1'b1);
        chk({req, " miss"}, {g_hit, g_ci, 62'd0} | g_ra, 64'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : stim
        logic [43:0] new_rpn;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 and R2: nothing valid out of reset
        chk("R1 idle res_valid", 64'(res_valid), 64'd0);
        look(64'h0, 1'b1);
        chk("R1 reset miss", 64'(g_hit), 64'd0);
        chk("R2 res_valid after lookup", 64'(g_vld), 64'd1);
        @(negedge clk);
        chk("R2 res_valid idle", {res_valid, res_hit, res_ci, 61'd0} | res_ra, 64'd0);

        // R3, R4: real-mode sweep over the window nibble
        for (int n = 0; n < 16; n++) begin
            logic [63:0] ea;
            ea = {32'h8765_4321, 4'(n), 28'h5A5_1234};
            look(ea, 1'b0);
            chk("R3 real hit", 64'(g_hit), 64'd1);
            chk("R3 real ra", g_ra, ea);
            chk("R4 real ci", 64'(g_ci), 64'(n == 12));
        end

        // R8: fill both ways of every set
        for (int s = 0; s < 64; s++) begin
            fill(tag_a(s), s, rpn_of(tag_a(s), s), tag_a(s)[0]);
            fill(tag_b(s), s, rpn_of(tag_b(s), s), ~tag_a(s)[0]);
        end
        // R5, R7: every entry translates
        for (int s = 0; s < 64; s++) begin
            expect_hit("R5 way a", tag_a(s), s, rpn_of(tag_a(s), s), tag_a(s)[0]);
            expect_hit("R7 way b", tag_b(s), s, rpn_of(tag_b(s), s), ~tag_a(s)[0]);
        end

        // R6: unknown page misses with zero outputs
        expect_miss("R6", 46'h3FFF, 3);

        // R9: replacement order in set 5 (rr is 0 after two fills)
        fill(46'h2005, 5, rpn_of(46'h2005, 5), 1'b0);
        expect_miss("R9 A evicted", tag_a(5), 5);
        expect_hit("R9 B kept", tag_b(5), 5, rpn_of(tag_b(5), 5), ~tag_a(5)[0]);
        expect_hit("R9 C in", 46'h2005, 5, rpn_of(46'h2005, 5), 1'b0);
        fill(46'h3005, 5, rpn_of(46'h3005, 5), 1'b1);
        expect_miss("R9 B evicted", tag_b(5), 5);
        expect_hit("R9 C kept", 46'h2005, 5, rpn_of(46'h2005, 5), 1'b0);
        expect_hit("R9 D in", 46'h3005, 5, rpn_of(46'h3005, 5), 1'b1);
        new_rpn = 44'h0AB_CDEF_0123;
        fill(46'h2005, 5, new_rpn, 1'b1);
        expect_hit("R9 C rewritten", 46'h2005, 5, new_rpn, 1'b1);
        expect_hit("R9 D kept on rewrite", 46'h3005, 5, rpn_of(46'h3005, 5), 1'b1);
        fill(46'h4005, 5, rpn_of(46'h4005, 5), 1'b0);
        expect_miss("R9 D evicted", 46'h3005, 5);
        expect_hit("R9 C still", 46'h2005, 5, new_rpn, 1'b1);
        expect_hit("R9 E in", 46'h4005, 5, rpn_of(46'h4005, 5), 1'b0);

        // R10: single-page clear in set 7
        fill(tag_a(7), 40, rpn_of(tag_a(7), 40), 1'b0);
        cmd({tag_a(7), 6'd7, 12'h000}, 64'h0);
        expect_miss("R10 page cleared", tag_a(7), 7);
        expect_hit("R10 other way", tag_b(7), 7, rpn_of(tag_b(7), 7), ~tag_a(7)[0]);
        expect_hit("R10 same tag other set", tag_a(7), 40, rpn_of(tag_a(7), 40), 1'b0);
        expect_hit("R10 neighbour set", tag_a(8), 8, rpn_of(tag_a(8), 8), tag_a(8)[0]);

        // R12: lookups concurrent with commands see the old state
        look_cmd(ea_of(tag_a(11), 11, 24), {tag_a(11), 6'd11, 12'h000}, 64'h0);
        chk("R12 old hit during clear", 64'(g_hit), 64'd1);
        expect_miss("R12 cleared next cycle", tag_a(11), 11);
        look_cmd(ea_of(tag_a(11), 11, 24), {tag_a(11), 6'd11, 12'h200},
                 pte_of(rpn_of(tag_a(11), 11), 1'b0));
        chk("R12 old miss during fill", 64'(g_hit), 64'd0);
        expect_hit("R12 filled next cycle", tag_a(11), 11, rpn_of(tag_a(11), 11), 1'b0);

        // R7, R11: sweep of action codes (001 is the write code)
        for (int code = 0; code < 8; code++) begin
            logic [63:0] x_ea, y_ea;
            if (code == 1) continue;
            x_ea = 64'h0000_0012_C000_9000;
            y_ea = 64'h0000_0034_0000_A000;
            cmd({x_ea[63:12], 12'h200}, pte_of(44'h111_2222_3333, 1'b0));
            cmd({y_ea[63:12], 12'h200}, pte_of(44'h444_5555_6666, 1'b1));
            look(x_ea | 64'h5C, 1'b1);
            chk("R5 translated ignores window hit", 64'(g_hit), 64'd1);
            chk("R5 translated ignores window ci", 64'(g_ci), 64'd0);
            chk("R8 written ra", g_ra, {8'h00, 44'h111_2222_3333, 12'h05C});
            cmd({x_ea[63:12], 3'(code), 9'h000}, 64'h0);
            look(x_ea, 1'b1);
            chk("R7 target cleared", 64'(g_hit), 64'd0);
            look(y_ea, 1'b1);
            chk("R11 clear-all by code", 64'(g_hit), 64'(code == 0));
        end
        expect_miss("R11 after clear-all", tag_b(20), 20);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule